// File: doc/BRIEF.md
# Biphase-Mark Audio Subframe Transmitter

This block turns a stream of audio samples into a two-channel consumer digital audio line signal. It runs on a cell clock of 128 times the sample rate, so one clock is one half-bit cell. That gives 64 cells per subframe and 128 per frame. For each subframe it asks the upstream unpacker for one sample. It then assembles a 32-bit subframe and drives it out as a biphase-mark waveform. The subframe holds a sync pattern, the audio bits, the validity, user and channel-status bits, and a parity bit. Subframes alternate between channel A and channel B. The usual rates from 32 kHz to 192 kHz all map onto the same cell clock ratio.

Channel status comes from two separate 192-bit banks, one for each channel, each filled as six 32-bit words through a small write port. Software can override the validity and user bits. Forcing the validity bit high marks samples invalid, and a receiver uses that as a digital mute.

Top module: `spdif_bmc_tx`

## Requirements
- R1: While `enable_i` is low, `line_o` holds 0 from the next clock onward, and `sample_req_o` stays low. At reset, both outputs are 0.
- R2: In the cycle `enable_i` is first seen high, `sample_req_o` pulses. After that it pulses exactly once every 64 clocks, in the last cell of each subframe, and `sample_i`, `sample_v_i` and `sample_u_i` are captured in that cycle. The first cell of that subframe appears on `line_o` two clocks after the request.
- R3: The sample sits in subframe bits 4 to 27, with its MSB at bit 27. Bits go out in ascending bit order, so the sample LSB is sent first.
- R4: Bit 28 (validity) equals `v_value_i` when `v_force_i` is 1, and `sample_v_i` otherwise.
- R5: Bit 29 (user) equals `u_value_i` when `u_force_i` is 1, and `sample_u_i` otherwise.
- R6: Bit 30 is status bit f of the channel's bank, where f is the frame index 0 to 191. Status bit f is bit f mod 32 of word f/32. A write with `cs_wr_i`=1 stores `cs_data_i` into word `cs_word_i` (0 to 5) of bank A when `cs_chan_i`=0, or of bank B when `cs_chan_i`=1.
- R7: Bit 31 makes the count of ones in bits 4 to 31 even.
- R8: Cells 0 to 7 carry the sync pattern, cell 0 first. The patterns are 11101000 (block start, channel A of frame 0), 11100010 (channel A of any other frame) and 11100100 (channel B). Each pattern is inverted when the line level before the subframe is 1.
- R9: Each of bits 4 to 31 begins with a level change. A 1 adds a second change at mid-bit, and a 0 does not.
- R10: The frame index counts 0 to 191 and then wraps to 0. Each time `enable_i` rises, output restarts at channel A of frame 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock, 128 x sample rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable_i | input | 1 | Run the transmitter |
| sample_i | input | 24 | Audio sample, captured on request |
| sample_v_i | input | 1 | Per-sample validity flag |
| sample_u_i | input | 1 | Per-sample user bit |
| sample_req_o | output | 1 | Sample capture strobe |
| v_force_i | input | 1 | Use `v_value_i` for the validity bit |
| v_value_i | input | 1 | Forced validity value (1 = mute) |
| u_force_i | input | 1 | Use `u_value_i` for the user bit |
| u_value_i | input | 1 | Forced user value |
| cs_wr_i | input | 1 | Channel-status word write strobe |
| cs_chan_i | input | 1 | Bank select, 0 = A, 1 = B |
| cs_word_i | input | 3 | Word index within the bank |
| cs_data_i | input | 32 | Word write data |
| line_o | output | 1 | Biphase-mark line output |

## Verification
The sample stream mixes all-ones, all-zeros and shifted counter patterns, so misplaced or reversed audio bits show up. The per-sample validity and user flags toggle at different rates, and the run passes through phases where each flag is forced to the opposite value, which separates forced from passed-through bits. The two status banks hold different non-periodic words, so a swapped bank, word or bit order changes bit 30. The run goes past 192 frames to reach the block-start wrap, and is then stopped mid-subframe and restarted to show the idle level and the restart at frame 0.

// File: rtl/spdif_tx_pkg.sv
package spdif_tx_pkg;

    localparam int SUBFRAME_BITS = 32;
    localparam int SYNC_BITS     = 4;
    localparam int CELLS_PER_SUB = 2 * SUBFRAME_BITS;
    localparam int AUDIO_MSB_POS = 27;
    localparam int V_POS         = 28;
    localparam int U_POS         = 29;
    localparam int C_POS         = 30;
    localparam int P_POS         = 31;

    typedef enum logic [1:0] {
        SYNC_BLK = 2'd0,
        SYNC_A   = 2'd1,
        SYNC_B   = 2'd2
    } sync_kind_e;

    // Cell pattern for a line level of 0 before the subframe; cell 0 is the MSB.
    function automatic logic [7:0] sync_cells(sync_kind_e k);
        case (k)
            SYNC_BLK: sync_cells = 8'b1110_1000;
            SYNC_A:   sync_cells = 8'b1110_0010;
            default:  sync_cells = 8'b1110_0100;
        endcase
    endfunction

endpackage

// File: rtl/spdif_cs_bank.sv
module spdif_cs_bank #(
    parameter int CS_BITS  = 192,
    parameter int WORD_W   = 32,
    localparam int WORDS   = CS_BITS / WORD_W,
    localparam int WIDX_W  = $clog2(WORDS),
    localparam int FRAME_W = $clog2(CS_BITS),
    localparam int BIT_W   = $clog2(WORD_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en_i,
    input  logic               wr_chan_i,
    input  logic [WIDX_W-1:0]  wr_word_i,
    input  logic [WORD_W-1:0]  wr_data_i,
    input  logic               rd_chan_i,
    input  logic [FRAME_W-1:0] rd_frame_i,
    output logic               rd_bit_o
);

    logic [WORD_W-1:0] mem_d [2][WORDS];
    logic [WORD_W-1:0] mem_q [2][WORDS];

    always_comb begin
        mem_d = mem_q;
        for (int ch = 0; ch < 2; ch++) begin
            for (int w = 0; w < WORDS; w++) begin
                if (wr_en_i && (wr_chan_i == ch[0]) && (wr_word_i == WIDX_W'(w))) begin
                    mem_d[ch][w] = wr_data_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int ch = 0; ch < 2; ch++) begin
                for (int w = 0; w < WORDS; w++) begin
                    mem_q[ch][w] <= '0;
                end
            end
        end else begin
            mem_q <= mem_d;
        end
    end

    // Status bit f lives in word f / WORD_W at position f mod WORD_W.
    always_comb begin
        int fi;
        fi = int'(rd_frame_i);
        rd_bit_o = 1'b0;
        for (int w = 0; w < WORDS; w++) begin
            if ((fi / WORD_W) == w) begin
                rd_bit_o = mem_q[rd_chan_i][w][BIT_W'(fi % WORD_W)];
            end
        end
    end

endmodule

// File: rtl/spdif_subframe_build.sv
module spdif_subframe_build
    import spdif_tx_pkg::*;
#(
    parameter int SAMPLE_W = 24
) (
    input  logic [SAMPLE_W-1:0]      sample_i,
    input  logic                     v_i,
    input  logic                     u_i,
    input  logic                     c_i,
    output logic [SUBFRAME_BITS-1:0] word_o
);

    // Sync bits 0..3 are left zero here; the encoder emits the sync pattern.
    always_comb begin
        word_o = '0;
        word_o[AUDIO_MSB_POS -: SAMPLE_W] = sample_i;
        word_o[V_POS] = v_i;
        word_o[U_POS] = u_i;
        word_o[C_POS] = c_i;
        word_o[P_POS] = ^word_o[C_POS:SYNC_BITS];
    end

endmodule

// File: rtl/spdif_bmc_enc.sv
module spdif_bmc_enc
    import spdif_tx_pkg::*;
#(
    localparam int CELL_W = $clog2(CELLS_PER_SUB),
    localparam int BIDX_W = CELL_W - 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     active_i,
    input  logic [CELL_W-1:0]        cell_i,
    input  logic [SUBFRAME_BITS-1:0] word_i,
    input  sync_kind_e               kind_i,
    output logic                     line_o
);

    typedef struct packed {
        logic line;
        logic lvl_ref;
    } enc_state_t;

    enc_state_t d, q;

    logic [BIDX_W-1:0] bit_idx;
    logic              second_half;
    logic              ref_now;
    logic [7:0]        pat;

    always_comb begin
        bit_idx     = cell_i[CELL_W-1:1];
        second_half = cell_i[0];
        ref_now     = (cell_i == '0) ? q.line : q.lvl_ref;
        pat         = sync_cells(kind_i);
        d           = q;
        if (!active_i) begin
            d.line    = 1'b0;
            d.lvl_ref = 1'b0;
        end else if (bit_idx < BIDX_W'(SYNC_BITS)) begin
            d.line    = pat[~cell_i[2:0]] ^ ref_now;
            d.lvl_ref = ref_now;
        end else if (!second_half) begin
            d.line = ~q.line;
        end else begin
            d.line = word_i[bit_idx] ? ~q.line : q.line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign line_o = q.line;

    // R9: every data bit opens with a level change
    p_cell_edge_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && (bit_idx >= BIDX_W'(SYNC_BITS)) && !second_half)
        |=> (q.line != $past(q.line)));

    // R8: every sync pattern opens with a level change
    p_sync_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && (cell_i == '0)) |=> (q.line != $past(q.line)));

endmodule

// File: rtl/spdif_bmc_tx.sv
module spdif_bmc_tx
    import spdif_tx_pkg::*;
#(
    parameter int SAMPLE_W   = 24,
    parameter int CS_BITS    = 192,
    parameter int CS_WORD_W  = 32,
    localparam int CS_WORDS  = CS_BITS / CS_WORD_W,
    localparam int CS_WIDX_W = $clog2(CS_WORDS),
    localparam int FRAME_W   = $clog2(CS_BITS),
    localparam int CELL_W    = $clog2(CELLS_PER_SUB),
    localparam int POS_W     = CELL_W + 1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable_i,
    input  logic [SAMPLE_W-1:0]  sample_i,
    input  logic                 sample_v_i,
    input  logic                 sample_u_i,
    output logic                 sample_req_o,
    input  logic                 v_force_i,
    input  logic                 v_value_i,
    input  logic                 u_force_i,
    input  logic                 u_value_i,
    input  logic                 cs_wr_i,
    input  logic                 cs_chan_i,
    input  logic [CS_WIDX_W-1:0] cs_word_i,
    input  logic [CS_WORD_W-1:0] cs_data_i,
    output logic                 line_o
);

    typedef struct packed {
        logic                     run;
        logic [POS_W-1:0]         pos;
        logic [FRAME_W-1:0]       frame;
        logic [SUBFRAME_BITS-1:0] word;
        sync_kind_e               kind;
    } tx_state_t;

    tx_state_t d, q;

    logic                     load;
    logic                     next_chan;
    logic [FRAME_W-1:0]       next_frame;
    logic                     cs_bit;
    logic [SUBFRAME_BITS-1:0] built_word;

    spdif_cs_bank #(
        .CS_BITS (CS_BITS),
        .WORD_W  (CS_WORD_W)
    ) cs_bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en_i    (cs_wr_i),
        .wr_chan_i  (cs_chan_i),
        .wr_word_i  (cs_word_i),
        .wr_data_i  (cs_data_i),
        .rd_chan_i  (next_chan),
        .rd_frame_i (next_frame),
        .rd_bit_o   (cs_bit)
    );

    spdif_subframe_build #(
        .SAMPLE_W (SAMPLE_W)
    ) build_i (
        .sample_i (sample_i),
        .v_i      (v_force_i ? v_value_i : sample_v_i),
        .u_i      (u_force_i ? u_value_i : sample_u_i),
        .c_i      (cs_bit),
        .word_o   (built_word)
    );

    always_comb begin
        load      = enable_i && (!q.run || (q.pos[CELL_W-1:0] == '1));
        next_chan = q.run ? ~q.pos[POS_W-1] : 1'b0;
        if (!q.run) begin
            next_frame = '0;
        end else if (q.pos == '1) begin
            next_frame = (q.frame == FRAME_W'(CS_BITS - 1)) ? '0 : q.frame + 1'b1;
        end else begin
            next_frame = q.frame;
        end

        d = q;
        if (!enable_i) begin
            d.run   = 1'b0;
            d.pos   = '0;
            d.frame = '0;
        end else begin
            d.run   = 1'b1;
            d.pos   = q.run ? q.pos + 1'b1 : '0;
            d.frame = next_frame;
            if (load) begin
                d.word = built_word;
                if (next_chan)              d.kind = SYNC_B;
                else if (next_frame == '0)  d.kind = SYNC_BLK;
                else                        d.kind = SYNC_A;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign sample_req_o = load;

    spdif_bmc_enc enc_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (enable_i && q.run),
        .cell_i   (q.pos[CELL_W-1:0]),
        .word_i   (q.word),
        .kind_i   (q.kind),
        .line_o   (line_o)
    );

    // R1: disabled transmitter idles low
    p_idle_line_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable_i |=> !line_o);

    // R2: requests never come back to back
    p_req_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req_o |=> !sample_req_o);

    // R7: a captured subframe carries even parity over bits 4..31
    p_parity_r7: assert property (@(posedge clk) disable iff (!rst_n)
        sample_req_o |=> ((^q.word[P_POS:SYNC_BITS]) == 1'b0));

    // R10: frame index stays inside the status block
    p_frame_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
        q.frame < FRAME_W'(CS_BITS));

endmodule

// File: tb/spdif_bmc_tx_tb.sv
module spdif_bmc_tx_tb_top;

    localparam int CLK_PERIOD = 8;
    localparam int QTR        = CLK_PERIOD / 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable_i = 1'b0;
    logic [23:0] sample_i = '0;
    logic        sample_v_i = 1'b0;
    logic        sample_u_i = 1'b0;
    logic        sample_req_o;
    logic        v_force_i = 1'b0;
    logic        v_value_i = 1'b0;
    logic        u_force_i = 1'b0;
    logic        u_value_i = 1'b0;
    logic        cs_wr_i = 1'b0;
    logic        cs_chan_i = 1'b0;
    logic [2:0]  cs_word_i = '0;
    logic [31:0] cs_data_i = '0;
    logic        line_o;

    always #(CLK_PERIOD / 2) clk = ~clk;

    spdif_bmc_tx dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable_i     (enable_i),
        .sample_i     (sample_i),
        .sample_v_i   (sample_v_i),
        .sample_u_i   (sample_u_i),
        .sample_req_o (sample_req_o),
        .v_force_i    (v_force_i),
        .v_value_i    (v_value_i),
        .u_force_i    (u_force_i),
        .u_value_i    (u_value_i),
        .cs_wr_i      (cs_wr_i),
        .cs_chan_i    (cs_chan_i),
        .cs_word_i    (cs_word_i),
        .cs_data_i    (cs_data_i),
        .line_o       (line_o)
    );

    typedef struct {
        int          kind;
        logic [23:0] s;
        logic        v;
        logic        u;
        logic        c;
        int          frame;
    } exp_t;

    exp_t     sb_q[$];
    logic     cs_a[192];
    logic     cs_b[192];
    int       n_checks = 0;
    int       n_fail = 0;
    int       done_sf = 0;
    longint   cyc = 0;
    bit       finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [23:0] gen_sample(int n);
        logic [7:0] b;
        b = 8'(n);
        if (n == 1) return 24'hFFFFFF;
        if (n == 2) return 24'h000000;
        return {b, ~b, b ^ 8'h5A};
    endfunction

    task automatic apply_inputs(int n);
        sample_i   = gen_sample(n);
        sample_v_i = n[2];
        sample_u_i = n[1] ^ n[3];
    endtask

    // Driver: on every request, predict the subframe and push it.
    initial begin
        int     n;
        bit     pend;
        longint last_req;
        exp_t   e;
        n = 0; pend = 0; last_req = -1;
        forever begin
            @(negedge clk);
            #(QTR);
            if (!enable_i) begin
                n = 0; pend = 0; last_req = -1;
                apply_inputs(0);
            end else if (sample_req_o) begin
                if (last_req >= 0)
                    check((cyc - last_req) == 64, "R2", "request spacing",
                          32'(cyc - last_req), 32'd64);
                last_req = cyc;
                e.frame = (n / 2) % 192;
                e.kind  = (n % 2 == 1) ? 2 : ((e.frame == 0) ? 0 : 1);
                e.s     = sample_i;
                e.v     = v_force_i ? v_value_i : sample_v_i;
                e.u     = u_force_i ? u_value_i : sample_u_i;
                e.c     = (n % 2 == 1) ? cs_b[e.frame] : cs_a[e.frame];
                sb_q.push_back(e);
                n++;
                pend = 1;
            end else if (pend) begin
                apply_inputs(n);
                pend = 0;
            end
        end
    end

    // Monitor: decode cells from the line and compare with the scoreboard.
    initial begin
        logic       cells[64];
        logic       prev;
        logic [7:0] got_sync;
        logic [7:0] exp_sync;
        logic [31:0] bits;
        bit         aborted;
        bit         bp_ok;
        exp_t       e;
        forever begin
            wait (enable_i === 1'b1);
            @(posedge clk);
            prev = 1'b0;
            aborted = 0;
            while (enable_i && !aborted) begin
                for (int k = 0; k < 64; k++) begin
                    @(posedge clk);
                    #(QTR);
                    if (!enable_i) begin
                        aborted = 1;
                        break;
                    end
                    cells[k] = line_o;
                end
                if (aborted) break;
                if (sb_q.size() == 0) begin
                    check(0, "R2", "subframe without request", 32'd0, 32'd1);
                end else begin
                    e = sb_q.pop_front();
                    for (int k = 0; k < 8; k++) got_sync[7-k] = cells[k];
                    case (e.kind)
                        0:       exp_sync = 8'b1110_1000;
                        1:       exp_sync = 8'b1110_0010;
                        default: exp_sync = 8'b1110_0100;
                    endcase
                    exp_sync = exp_sync ^ {8{prev}};
                    if (e.kind == 0)
                        check(got_sync == exp_sync, "R10", "block start sync", 32'(got_sync), 32'(exp_sync));
                    else
                        check(got_sync == exp_sync, "R8", "sync pattern", 32'(got_sync), 32'(exp_sync));
                    bits = '0;
                    bp_ok = 1;
                    for (int b = 4; b < 32; b++) begin
                        if (cells[2*b] == cells[2*b-1]) bp_ok = 0;
                        bits[b] = cells[2*b] ^ cells[2*b+1];
                    end
                    check(bp_ok, "R9", "cell boundary transition", 32'(bp_ok), 32'd1);
                    check(bits[27:4] == e.s, "R3", "audio bits", 32'(bits[27:4]), 32'(e.s));
                    check(bits[28] == e.v, "R4", "validity bit", 32'(bits[28]), 32'(e.v));
                    check(bits[29] == e.u, "R5", "user bit", 32'(bits[29]), 32'(e.u));
                    check(bits[30] == e.c, "R6", "status bit", 32'(bits[30]), 32'(e.c));
                    check(bits[31] == ^{e.c, e.u, e.v, e.s}, "R7", "parity bit",
                          32'(bits[31]), 32'(^{e.c, e.u, e.v, e.s}));
                end
                prev = cells[63];
                done_sf++;
            end
            wait (enable_i === 1'b0);
        end
    end

    task automatic write_cs(input logic ch, input int w, input logic [31:0] data);
        @(negedge clk);
        cs_wr_i = 1'b1; cs_chan_i = ch; cs_word_i = 3'(w); cs_data_i = data;
        @(negedge clk);
        cs_wr_i = 1'b0;
        for (int i = 0; i < 32; i++) begin
            if (ch) cs_b[w*32+i] = data[i];
            else    cs_a[w*32+i] = data[i];
        end
    endtask

    task automatic check_idle(input int cycles);
        bit ok;
        ok = 1;
        @(posedge clk);
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (line_o !== 1'b0 || sample_req_o !== 1'b0) ok = 0;
        end
        check(ok, "R1", "idle output and no request", 32'({line_o, sample_req_o}), 32'd0);
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        for (int i = 0; i < 192; i++) begin
            cs_a[i] = 1'b0;
            cs_b[i] = 1'b0;
        end
        repeat (3) @(negedge clk);
        check(line_o === 1'b0 && sample_req_o === 1'b0, "R1", "reset state",
              32'({line_o, sample_req_o}), 32'd0);
        rst_n = 1'b1;
        check_idle(20);

        for (int w = 0; w < 6; w++) begin
            write_cs(1'b0, w, 32'hA5C3_0F01 ^ (32'(w) * 32'h1357_9BDF));
            write_cs(1'b1, w, 32'h3C96_E10E ^ (32'(w) * 32'h0246_8ACE));
        end

        @(negedge clk);
        enable_i = 1'b1;
        wait (done_sf >= 100);
        @(negedge clk);
        v_force_i = 1'b1; v_value_i = 1'b1;   // mute
        wait (done_sf >= 150);
        @(negedge clk);
        u_force_i = 1'b1; u_value_i = 1'b0;
        wait (done_sf >= 200);
        @(negedge clk);
        v_value_i = 1'b0; u_value_i = 1'b1;
        wait (done_sf >= 260);
        @(negedge clk);
        v_force_i = 1'b0; u_force_i = 1'b0;
        wait (done_sf >= 410);
        @(negedge clk);
        enable_i = 1'b0;
        check_idle(100);
        sb_q.delete();

        write_cs(1'b0, 0, 32'h0000_0001);
        @(negedge clk);
        enable_i = 1'b1;
        wait (done_sf >= 416);
        @(negedge clk);
        enable_i = 1'b0;
        check_idle(30);
        finish_run();
    end

endmodule